// File: doc/BRIEF.md
# Freezable Channel Activity Counters

This block keeps four 32-bit activity counters for a radio MAC. The first counts every clock cycle. The second counts the cycles in which the receive medium is busy. The third counts the cycles spent receiving a frame, and the fourth counts the cycles spent transmitting one. All four step at once from per-cycle status inputs. Together they give the share of airtime that the channel was idle, busy, receiving or transmitting.

Software uses a small register port to take a coherent snapshot. It first sets a single freeze bit, which halts all four counters on the same clock edge. It then reads the four values, writes zero to each one, and clears the freeze bit. Because nothing advances between the first read and the last, the four values always describe the same stretch of time. Host software can then work out the idle listen time as the total minus receive-frame minus transmit-frame cycles, divided by the clock rate in MHz times 1000.

Top module: `chan_activity_counters`

## Requirements
- R1: During and after a synchronous active-high reset, all counters are zero and the freeze bit is clear. `rd_valid` is low and `rd_data` is zero.
- R2: While the freeze bit is clear, the total counter (address 1) increases by one on every clock edge.
- R3: While the freeze bit is clear, the busy counter (address 2) increases on each edge at which `med_busy` is high. The receive-frame counter (address 3) does the same for `rx_active`, and the transmit-frame counter (address 4) for `tx_active`.
- R4: Writing 1 to bit 0 of the control register (address 0) sets the freeze bit. From the following edge on, none of the four counters changes unless it is written.
- R5: A write to a counter address loads `wr_data` into that counter, so writing zero clears it. This holds whether or not the counters are frozen. When a write and an increment meet on the same edge, the write wins.
- R6: Writing 0 to bit 0 of the control register clears the freeze bit, and counting resumes on the next edge.
- R7: Each counter stops at 0xFFFFFFFF and does not wrap to zero.
- R8: A read strobe produces `rd_valid` one cycle later, for exactly one cycle. `rd_data` then holds the value the addressed register had in the strobe cycle. The control register reads back the freeze bit in bit 0. Addresses 5 to 7 read as zero.
- R9: A snapshot of the four counters taken with the freeze, read, clear, unfreeze sequence matches the counts of the stimulus applied. The idle listen time computed from it is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| med_busy | input | 1 | Receive medium busy this cycle |
| rx_active | input | 1 | Receiving a frame this cycle |
| tx_active | input | 1 | Transmitting a frame this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 total, 2 busy, 3 receive, 4 transmit |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The bench aims at the edges where freeze takes effect and where it is released. A design that applied the freeze bit in the cycle it is written, or one cycle late, would be off by one in the total count over a known window. Writes are issued while the status input is high, so a design that let an increment override a clear would read back one more than the written value. A counter is preloaded just below all ones and left to run, so a design that wraps would read back a small number instead of 0xFFFFFFFF. A long random run of status inputs ends in a frozen snapshot whose four counts and derived listen time must agree with a behavioural model. A snapshot that is not coherent, or a counter wired to the wrong input, would show up as a mismatch there.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int NUM_CNT = 4;

  // counter order: index i answers at register address i+1
  typedef enum int {
    CNT_TOTAL = 0,
    CNT_BUSY  = 1,
    CNT_RXF   = 2,
    CNT_TXF   = 3
  } cnt_idx_e;

  localparam int ADDR_CTRL = 0;
  localparam int FRZ_BIT   = 0;
endpackage

// File: rtl/cac_counter.sv
module cac_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic at_top;
  assign at_top = (q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= ld_val;                 // write beats increment
    end else if (step && !at_top) begin
      q <= q + 1'b1;               // sticky at all ones
    end
  end
endmodule

// File: rtl/cac_regif.sv
module cac_regif
  import cac_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 3,
  parameter int N  = NUM_CNT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  input  logic [N*W-1:0] cnt_flat,
  output logic           frz,
  output logic [N-1:0]   ld,
  output logic [W-1:0]   rdata,
  output logic           rvalid
);
  localparam logic [AW-1:0] CTRL_A = AW'(ADDR_CTRL);

  logic         ctrl_hit;
  logic [W-1:0] sel;

  assign ctrl_hit = wr_en && (addr == CTRL_A);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ld[i] = wr_en && (addr == AW'(i + 1));
    end
  end

  always_comb begin
    sel = '0;
    if (addr == CTRL_A) begin
      sel[FRZ_BIT] = frz;
    end
    for (int i = 0; i < N; i++) begin
      if (addr == AW'(i + 1)) begin
        sel = cnt_flat[i*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frz <= 1'b0;
    end else if (ctrl_hit) begin
      frz <= wdata[FRZ_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= sel;
      end
    end
  end
endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
  import cac_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              med_busy,
  input  logic              rx_active,
  input  logic              tx_active,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_valid
);
  localparam int N = NUM_CNT;

  logic [N-1:0]       evt;
  logic [N-1:0]       ld;
  logic [N-1:0]       step;
  logic               frz;
  logic [N*CNT_W-1:0] cnt_flat;

  always_comb begin
    evt            = '0;
    evt[CNT_TOTAL] = 1'b1;
    evt[CNT_BUSY]  = med_busy;
    evt[CNT_RXF]   = rx_active;
    evt[CNT_TXF]   = tx_active;
  end

  assign step = frz ? '0 : evt;

  for (genvar g = 0; g < N; g++) begin : g_cnt
    cac_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld[g]),
      .ld_val (wr_data),
      .step   (step[g]),
      .q      (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  cac_regif #(.W(CNT_W), .AW(ADDR_W), .N(N)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (reg_addr),
    .wdata    (wr_data),
    .cnt_flat (cnt_flat),
    .frz      (frz),
    .ld       (ld),
    .rdata    (rd_data),
    .rvalid   (rd_valid)
  );
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
  parameter int W  = 32,
  parameter int AW = 3,
  parameter int N  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic [AW-1:0]  addr,
  input logic [W-1:0]   wdata,
  input logic [W-1:0]   rdata,
  input logic           rvalid,
  input logic           frz,
  input logic [N*W-1:0] cnt_flat
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] tot;
  assign tot = cnt_flat[W-1:0];

  // R1: reset leaves the read port quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rvalid && rdata == '0 && !frz));

  // R8: valid follows strobe by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  // R2: total steps by one while running
  a_r2_total_steps: assert property (@(posedge clk) disable iff (rst)
    (!frz && !(wr_en && addr == AW'(1)) && tot != TOP) |=> tot == $past(tot) + 1'b1);

  // R7: saturation is sticky
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (tot == TOP && !(wr_en && addr == AW'(1))) |=> tot == TOP);

  // R6: control write sets or clears freeze
  a_r6_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(0)) |=> frz == $past(wdata[0]));

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R4: frozen counters hold
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
      (frz && !(wr_en && addr == AW'(g + 1))) |=> $stable(cnt_flat[g*W +: W]));
    // R5: write loads the value
    a_r5_write_loads: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(g + 1)) |=> cnt_flat[g*W +: W] == $past(wdata));
  end
endmodule

bind chan_activity_counters cac_checker #(.W(CNT_W), .AW(ADDR_W), .N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (reg_addr),
  .wdata    (wr_data),
  .rdata    (rd_data),
  .rvalid   (rd_valid),
  .frz      (frz),
  .cnt_flat (cnt_flat)
);

// File: tb/chan_activity_counters_test.sv
`timescale 1ns/1ps
module chan_activity_counters_test;
  localparam longint MAXV    = 64'hFFFF_FFFF;
  localparam int     CLK_MHZ = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        med_busy = 1'b0, rx_active = 1'b0, tx_active = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_run = 0, n_fail = 0;
  bit started = 1'b0;

  longint m_cnt [4];
  bit     m_frz;
  longint m_rdata;
  bit     m_rvalid;

  always #5 clk = ~clk;

  chan_activity_counters uut (
    .clk(clk), .rst(rst), .med_busy(med_busy), .rx_active(rx_active),
    .tx_active(tx_active), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // behavioural reference, updated at each edge from stable inputs
  always @(posedge clk) begin
    bit ev [4];
    started = 1'b1;
    if (rst) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_frz = 0; m_rdata = 0; m_rvalid = 0;
    end else begin
      m_rvalid = rd_en;
      if (rd_en) begin
        if (reg_addr == 0) m_rdata = longint'(m_frz);
        else if (reg_addr <= 4) m_rdata = m_cnt[reg_addr - 1];
        else m_rdata = 0;
      end
      ev[0] = 1; ev[1] = med_busy; ev[2] = rx_active; ev[3] = tx_active;
      for (int i = 0; i < 4; i++) begin
        if (wr_en && reg_addr == 3'(i + 1)) m_cnt[i] = longint'(wr_data);
        else if (!m_frz && ev[i] && m_cnt[i] < MAXV) m_cnt[i] = m_cnt[i] + 1;
      end
      if (wr_en && reg_addr == 0) m_frz = wr_data[0];
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // lockstep comparison of the read port on every clock (R8)
  always @(negedge clk) begin
    if (started) begin
      check(rd_valid == m_rvalid, "R8 lockstep valid", longint'(rd_valid), longint'(m_rvalid));
      check(longint'(rd_data) == m_rdata, "R8 lockstep data", longint'(rd_data), m_rdata);
    end
  end

  task automatic wr_reg(input int a, input longint v);
    wr_en = 1; reg_addr = 3'(a); wr_data = 32'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_reg(input int a, output longint v);
    rd_en = 1; reg_addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    v = longint'(rd_data);
    check(rd_valid == 1'b1, "R8 valid after strobe", longint'(rd_valid), 1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R8 valid one cycle", longint'(rd_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    longint v, v2, snap [4], lt_dut, lt_ref;
    repeat (3) @(negedge clk);
    // R1
    check(rd_valid == 0, "R1 reset valid", longint'(rd_valid), 0);
    check(rd_data == 0, "R1 reset data", longint'(rd_data), 0);
    rst = 0;
    rd_reg(0, v);
    check(v == 0, "R1 freeze clear after reset", v, 0);

    // R4: freeze, then values hold while inputs toggle
    wr_reg(0, 1);
    rd_reg(1, v);
    med_busy = 1; rx_active = 1; tx_active = 1;
    repeat (10) @(negedge clk);
    rd_reg(1, v2);
    check(v == v2, "R4 total frozen", v2, v);
    rd_reg(0, v);
    check(v == 1, "R8 control reads freeze", v, 1);

    // R5: clear all while frozen
    for (int i = 1; i <= 4; i++) wr_reg(i, 0);
    for (int i = 1; i <= 4; i++) begin
      rd_reg(i, v);
      check(v == 0, "R5 clear while frozen", v, 0);
    end

    // R2/R3/R6: known window of N+1 counting edges
    med_busy = 1; rx_active = 0; tx_active = 1;
    wr_reg(0, 0);
    repeat (20) @(negedge clk);
    wr_reg(0, 1);
    med_busy = 0; tx_active = 0;
    rd_reg(1, v); check(v == 21, "R2 total over window", v, 21);
    rd_reg(2, v); check(v == 21, "R3 busy over window", v, 21);
    rd_reg(3, v); check(v == 0,  "R3 rx idle over window", v, 0);
    rd_reg(4, v); check(v == 21, "R6 resumed tx count", v, 21);

    // R5: write beats increment while running
    med_busy = 1;
    wr_reg(0, 0);
    wr_reg(2, 5);
    rd_reg(2, v);
    check(v == 5, "R5 write wins over increment", v, 5);

    // R7: saturation
    wr_reg(0, 1);
    rx_active = 1;
    wr_reg(3, 64'hFFFF_FFFD);
    wr_reg(0, 0);
    repeat (6) @(negedge clk);
    wr_reg(0, 1);
    rd_reg(3, v);
    check(v == MAXV, "R7 saturate", v, MAXV);

    // R8: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      rd_reg(a, v);
      check(v == 0, "R8 unmapped reads zero", v, 0);
    end

    // R9: random run then coherent snapshot and listen time
    for (int i = 1; i <= 4; i++) wr_reg(i, 0);
    wr_reg(0, 0);
    for (int c = 0; c < 6000; c++) begin
      case ($urandom_range(0, 3))
        0: begin med_busy = 0; rx_active = 0; tx_active = 0; end
        1: begin med_busy = 1; rx_active = 0; tx_active = 0; end
        2: begin med_busy = 1; rx_active = 1; tx_active = 0; end
        default: begin med_busy = 0; rx_active = 0; tx_active = 1; end
      endcase
      @(negedge clk);
    end
    wr_reg(0, 1);
    med_busy = 1; rx_active = 1; tx_active = 1;
    for (int i = 0; i < 4; i++) begin
      rd_reg(i + 1, snap[i]);
      check(snap[i] == m_cnt[i], "R9 snapshot vs model", snap[i], m_cnt[i]);
    end
    lt_dut = (snap[0] - snap[2] - snap[3]) / (CLK_MHZ * 1000);
    lt_ref = (m_cnt[0] - m_cnt[2] - m_cnt[3]) / (CLK_MHZ * 1000);
    check(lt_dut == lt_ref && lt_ref > 0, "R9 listen time", lt_dut, lt_ref);
    for (int i = 1; i <= 4; i++) wr_reg(i, 0);
    wr_reg(0, 0);
    med_busy = 0; rx_active = 0; tx_active = 0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule